// File: doc/BRIEF.md
# Mirrored Filter Kernel Coefficient Store

This block keeps the tap weights of a polyphase scaler filter: 32 signed 9-bit coefficients, packed three to a word in an 11-word store. A host loads it one word at a time through a write port. The filter datapath fetches any single coefficient through a tap-read port. That port returns the value sign-extended to 16 bits, one cycle after the request.

The lower half of the kernel is stored ascending: taps 0 to 16 sit in flat slots 0 to 16, and slot 17 is a pad. The upper half is stored so that a symmetric (linear-phase) kernel is the lower words replayed in reverse word order. For that case a mirror load mode is provided. The host writes only the six unique words. The block then copies words 4, 3, 2, 1 and 0 into words 6, 7, 8, 9 and 10 by itself, one per cycle, and signals busy while it does so.

Top module: `fk_coef_store`

## Requirements
- R1: Word w holds three 9-bit two's-complement fields: slot 0 in bits 8:0, slot 1 in bits 17:9 and slot 2 in bits 26:18. Bits 31:27 of written data are discarded. Tap k for k from 0 to 16 is read from word k/3, slot k%3.
- R2: Tap k for k from 17 to 31 is read as follows. Let m = k-17. The tap comes from word 6+m/3, slot 2-(m%3), so each upper word holds its taps in reverse slot order.
- R3: `rd_data_o` is the selected 9-bit field sign-extended to 16 bits.
- R4: A read request with `rd_en_i` high yields `rd_valid_o` high on the next cycle, with the data on `rd_data_o`. With no request, the next cycle shows `rd_valid_o` low and `rd_data_o` zero. A read in the same cycle as a write to the same word returns the old contents.
- R5: A write with `wr_addr_i` of 11 or more changes no word and raises `err_o` for exactly one cycle, on the next cycle.
- R6: A mirror-mode write (`wr_mirror_i` high) to word 5 starts the mirrored fill. `busy_o` is then high for exactly 5 cycles. During those cycles word 6+j receives word 4-j for j = 0 to 4, after which tap k equals tap 31-k for every k.
- R7: A read request accepted while `busy_o` is high returns zero, with `rd_valid_o` still high.
- R8: Any write presented while `busy_o` is high is ignored and raises `err_o` on the next cycle.
- R9: A mirror-mode write to a word address of 6 or more is ignored and raises `err_o` on the next cycle. Mirror-mode writes to words 0 to 4 store like plain writes.
- R10: After reset every word is zero, and `busy_o`, `err_o`, `rd_valid_o` and `rd_data_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word write strobe |
| wr_mirror_i | input | 1 | Write belongs to a linear-phase (mirror) load |
| wr_addr_i | input | 4 | Word address |
| wr_data_i | input | 32 | Packed word data |
| rd_en_i | input | 1 | Tap read request |
| rd_tap_i | input | 5 | Tap index 0 to 31 |
| rd_data_o | output | 16 | Sign-extended coefficient |
| rd_valid_o | output | 1 | Read result valid |
| busy_o | output | 1 | Mirrored fill in progress |
| err_o | output | 1 | Rejected write, one-cycle pulse |

## Verification
The bench goes after the following corner cases:

- **Upper-half slot order.** A design that kept the upper half in ascending slot order would return tap 19 where tap 17 belongs.
- **Sign extension.** A missing sign extension would show negative taps as large positive values.
- **Fill ordering and length.** An off-by-one fill, or a fill that copies in forward order, breaks the tap k = tap 31-k symmetry seen on the read port.
- **Busy window.** A busy flag held one cycle too long or too short shows up on `busy_o` against the reference model.
- **Rejected writes.** Out-of-range writes, writes during the fill and mirror writes beyond word 5 are each followed by a full tap sweep. Any write that leaked through would appear as a changed coefficient.

// File: rtl/fk_pkg.sv
package fk_pkg;
  localparam int TAP_W   = 9;
  localparam int SLOTS   = 3;
  localparam int N_TAPS  = 32;
  localparam int WORD_W  = 32;
  localparam int OUT_W   = 16;
  localparam int FIELD_W = TAP_W * SLOTS;
  localparam int N_WORDS = (N_TAPS + 1 + SLOTS - 1) / SLOTS;
  localparam int N_UNIQ  = (N_WORDS + 1) / 2;
  localparam int N_MIRR  = N_WORDS - N_UNIQ;
  localparam int ADDR_W  = $clog2(N_WORDS + 1);
  localparam int TAP_IW  = $clog2(N_TAPS);
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int FILL_W  = $clog2(N_MIRR + 1);
endpackage

// File: rtl/fk_wr_ctrl.sv
module fk_wr_ctrl
  import fk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_mirror_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [ADDR_W-1:0] fill_src_o,
  output logic              busy_o,
  output logic              err_o
);
  logic              busy_q, err_q;
  logic [FILL_W-1:0] cnt_q;
  logic              addr_oob, mirr_oob, reject, host_we, start;

  assign addr_oob = wr_addr_i >= ADDR_W'(N_WORDS);
  assign mirr_oob = wr_mirror_i && (wr_addr_i >= ADDR_W'(N_UNIQ));
  assign reject   = wr_en_i && (addr_oob || mirr_oob || busy_q);
  assign host_we  = wr_en_i && !reject;
  assign start    = host_we && wr_mirror_i && (wr_addr_i == ADDR_W'(N_UNIQ - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == FILL_W'(N_MIRR - 1)) busy_q <= 1'b0;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // fill walks destination upward while the source walks down
  assign mem_we_o    = host_we || busy_q;
  assign mem_waddr_o = busy_q ? ADDR_W'(N_UNIQ) + ADDR_W'(cnt_q) : wr_addr_i;
  assign fill_src_o  = ADDR_W'(N_UNIQ - 2) - ADDR_W'(cnt_q);
  assign busy_o      = busy_q;
  assign err_o       = err_q;
endmodule

// File: rtl/fk_word_mem.sv
module fk_word_mem
  import fk_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               waddr_i,
  input  logic [FIELD_W-1:0]              wdata_i,
  output logic [N_WORDS-1:0][FIELD_W-1:0] words_o
);
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [FIELD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '0;
      else if (we_i && (waddr_i == ADDR_W'(w)))      word_q <= wdata_i;
    end
    assign words_o[w] = word_q;
  end
endmodule

// File: rtl/fk_tap_rd.sv
module fk_tap_rd
  import fk_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_WORDS-1:0][FIELD_W-1:0] words_i,
  input  logic                            rd_en_i,
  input  logic [TAP_IW-1:0]               rd_tap_i,
  input  logic                            busy_i,
  output logic [OUT_W-1:0]                rd_data_o,
  output logic                            rd_valid_o
);
  localparam int HALF = N_TAPS / 2;

  logic [ADDR_W-1:0] w_idx;
  logic [SLOT_W-1:0] s_idx;
  logic [TAP_W-1:0]  field;
  logic [OUT_W-1:0]  data_q;
  logic              valid_q;

  always_comb begin
    int t, m;
    t = int'(rd_tap_i);
    m = t - HALF - 1;
    if (t <= HALF) begin
      w_idx = ADDR_W'(t / SLOTS);
      s_idx = SLOT_W'(t % SLOTS);
    end else begin
      // upper half: words ascend, slots reversed
      w_idx = ADDR_W'(N_UNIQ + m / SLOTS);
      s_idx = SLOT_W'(SLOTS - 1 - m % SLOTS);
    end
    field = words_i[w_idx][s_idx*TAP_W +: TAP_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en_i;
      data_q  <= (rd_en_i && !busy_i) ? {{(OUT_W-TAP_W){field[TAP_W-1]}}, field} : '0;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/fk_coef_store.sv
module fk_coef_store
  import fk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_mirror_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [TAP_IW-1:0] rd_tap_i,
  output logic [OUT_W-1:0]  rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              err_o
);
  logic [N_WORDS-1:0][FIELD_W-1:0] words;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, fill_src;
  logic [FIELD_W-1:0] mem_wdata;
  logic              busy;
  logic              unused_hi;

  assign unused_hi = ^wr_data_i[WORD_W-1:FIELD_W];

  fk_wr_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_en_i, .wr_mirror_i, .wr_addr_i,
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .fill_src_o(fill_src),
    .busy_o(busy), .err_o
  );

  assign mem_wdata = busy ? words[fill_src] : wr_data_i[FIELD_W-1:0];

  fk_word_mem u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .words_o(words)
  );

  fk_tap_rd u_rd (
    .clk_i, .rst_ni, .words_i(words), .rd_en_i, .rd_tap_i,
    .busy_i(busy), .rd_data_o, .rd_valid_o
  );

  assign busy_o = busy;
endmodule

// File: rtl/fk_coef_store_chk.sv
module fk_coef_store_chk
  import fk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              rd_en_i,
  input logic [OUT_W-1:0]  rd_data_o,
  input logic              rd_valid_o,
  input logic              busy_o,
  input logic              err_o
);
  logic [FILL_W:0] busy_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= '0;
    else if (busy_o) busy_run <= busy_run + 1'b1;
    else             busy_run <= '0;
  end

  a_r4_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && rd_data_o == '0));
  a_r3_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_data_o[OUT_W-1:TAP_W-1] == '0 || rd_data_o[OUT_W-1:TAP_W-1] == '1));
  a_r5_range_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(N_WORDS)) |=> err_o);
  a_r8_busy_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_o) |=> err_o);
  a_r7_busy_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && busy_o) |=> rd_data_o == '0);
  a_r6_fill_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run < (FILL_W+1)'(N_MIRR));
  a_r6_fill_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(busy_run) == (FILL_W+1)'(N_MIRR - 1));
endmodule

bind fk_coef_store fk_coef_store_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
  .busy_o(busy_o), .err_o(err_o)
);

// File: tb/fk_coef_store_tb.sv
module fk_coef_store_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_mir, rd_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd_tap;
  logic [15:0] rd_data;
  logic        rd_valid, busy, err;

  always #(PERIOD/2) clk = ~clk;

  fk_coef_store dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_mirror_i(wr_mir),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_tap_i(rd_tap),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .busy_o(busy), .err_o(err)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R10";

  int    m_mem [11];
  bit    m_busy;
  int    m_cnt;
  logic [15:0] e_data;
  logic        e_valid, e_busy, e_err;

  function automatic logic [15:0] tap_val(int k);
    int w, s, f;
    if (k <= 16) begin w = k / 3; s = k % 3; end
    else begin w = 6 + (k - 17) / 3; s = 2 - (k - 17) % 3; end
    f = (m_mem[w] >> (s * 9)) & 'h1FF;
    if (f >= 256) f = f - 512;
    return 16'(f);
  endfunction

  task automatic check(string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit bad;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 0;
      m_busy = 0; m_cnt = 0;
      e_data = 0; e_valid = 0; e_err = 0;
    end else begin
      e_valid = rd_en;
      e_data  = (rd_en && !m_busy) ? tap_val(int'(rd_tap)) : 16'h0;
      bad = wr_en && (wr_addr > 10 || m_busy || (wr_mir && wr_addr > 5));
      e_err = bad;
      if (m_busy) begin
        m_mem[6 + m_cnt] = m_mem[4 - m_cnt];
        m_cnt++;
        if (m_cnt == 5) m_busy = 0;
      end else if (wr_en && !bad) begin
        m_mem[wr_addr] = int'(wr_data & 32'h07FF_FFFF);
        if (wr_mir && wr_addr == 5) begin m_busy = 1; m_cnt = 0; end
      end
    end
    e_busy = m_busy;
    @(negedge clk);
    check("rd_valid", 16'(rd_valid), 16'(e_valid));
    check("rd_data", rd_data, e_data);
    check("busy", 16'(busy), 16'(e_busy));
    check("err", 16'(err), 16'(e_err));
  endtask

  task automatic idle();
    wr_en = 0; wr_mir = 0; rd_en = 0;
  endtask

  task automatic wr(int a, logic [31:0] d, bit mir);
    wr_en = 1; wr_mir = mir; wr_addr = 4'(a); wr_data = d;
    cyc();
    wr_en = 0; wr_mir = 0;
  endtask

  task automatic sweep();
    for (int t = 0; t < 32; t++) begin
      rd_en = 1; rd_tap = 5'(t);
      cyc();
    end
    rd_en = 0;
    cyc();
  endtask

  function automatic logic [31:0] pack(int a, int b, int c);
    return {5'h0, 9'(c), 9'(b), 9'(a)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k[16] = '{0, -1, -4, -9, -12, -10, -5, 3, 16, 40, 75, 110, 150, 185, 210, 230};
    rst_n = 0; idle(); wr_addr = 0; wr_data = 0; rd_tap = 0;
    // R10: reset state
    tag = "R10";
    @(negedge clk); cyc(); cyc();
    rst_n = 1;
    rd_en = 1; rd_tap = 5'd20; cyc();
    rd_tap = 5'd2; cyc();
    idle(); cyc();

    // R1 R2 R3: full load with negative fields and junk in bits 31:27
    tag = "R1";
    wr(0, {5'h1F, 9'h1FF, 9'h100, 9'h0FF}, 0);
    for (int i = 1; i < 11; i++)
      wr(i, 32'hF800_0000 ^ (32'(i) * 32'h0123_4567) ^ pack(i, -i, 3*i+100), 0);
    tag = "R2"; sweep();
    // R4: read of a word in the same cycle it is rewritten returns old value
    tag = "R4";
    rd_en = 1; rd_tap = 5'd3; wr_en = 1; wr_addr = 4'd1; wr_data = pack(-77, 5, 6);
    cyc(); idle(); rd_en = 1; rd_tap = 5'd3; cyc(); idle(); cyc();

    // R5: out-of-range writes ignored
    tag = "R5";
    wr(11, 32'h0, 0); wr(15, 32'h07FF_FFFF, 0); cyc();
    sweep();

    // R9: mirror write beyond unique words ignored, below stored
    tag = "R9";
    wr(7, 32'h0, 1); wr(10, 32'h0, 1); cyc(); sweep();

    // R6: mirror load of a symmetric kernel
    tag = "R6";
    for (int i = 0; i < 5; i++) wr(i, pack(k[3*i], k[3*i+1], k[3*i+2]), 1);
    rd_en = 1; rd_tap = 5'd4;
    wr(5, pack(k[15], k[15], 0), 1);
    tag = "R7";
    rd_tap = 5'd0;  cyc();
    rd_tap = 5'd31; cyc();
    tag = "R8";
    wr(0, 32'h0, 0);
    wr(20, 32'h0, 1);
    tag = "R7";
    rd_tap = 5'd16; cyc();
    rd_tap = 5'd9;  cyc();
    idle(); cyc();
    tag = "R6"; sweep();
    // explicit symmetry through the read port
    for (int t = 0; t < 16; t++) begin
      logic [15:0] lo;
      rd_en = 1; rd_tap = 5'(t); cyc(); lo = rd_data;
      rd_tap = 5'(31 - t); cyc();
      check("symmetry", rd_data, lo);
    end
    idle(); cyc();
    finish_run();
  end
endmodule